// File: doc/BRIEF.md
# Teletext Bit Pacer and Data Request

This block sets the pace for serial teletext insertion on a 625-line raster that runs from a 27 MHz clock. The line's timing generator supplies the horizontal cycle count and the frame line number. On a line that may carry teletext, the block raises a request output so that an external source can start shifting data bits onto a serial input. The input is expected to change on rising clock edges.

A line carries 444 bit periods in 1728 clocks. That ratio is not an integer, so the block builds every bit period from a fixed 37-bit group of 144 clocks. Four positions in each group last three clocks and the other positions last four. At the last clock of each bit period the block emits a one-cycle valid strobe and the data bit captured on that clock. The request can be moved earlier by a programmable number of clocks to cover the source's latency. A test mode replaces the source with an alternating one/zero pattern.

The register inputs are a global enable, per-line enables for both fields, a request advance and a test-pattern enable. They come from an external control bank.

Top module: `ttx_pacer`

## Requirements
- R1: While reset is asserted (active low, asynchronous), and on the first clock after it is released, `ttxReq`, `bitValid` and `bitData` are all 0.
- R2: A line is eligible only when `is625Mode` and `ttxEnable` are both 1 and one of the following holds: `lineNum` is 6 to 22 with `oddLineEn[lineNum-6]` set, or `lineNum` is 318 to 335 with `evenLineEn[lineNum-318]` set. On any other line, all three outputs stay 0 for the whole line.
- R3: On an eligible line, bit periods start at horizontal count `WIN_START` (default 264) and follow one another with no gap, for `NUM_BITS` periods (default 360). Count the positions 1 to 37 inside each repeating group. Positions 10, 19, 28 and 37 last 3 clocks and all others last 4, so each whole group takes 144 clocks. No strobe occurs after the last bit of the line.
- R4: `bitValid` is a one-clock pulse for the last clock of each bit period. It is registered, so it appears on the clock after the one where `hCount` holds that last count.
- R5: When `bitValid` is 1 and the test mode is off, `bitData` is the value of `ttxDataIn` sampled at the same clock edge that registers the strobe. When `bitValid` is 0, `bitData` is 0.
- R6: With `testPatEn` set, `bitData` ignores `ttxDataIn`. It is 1 for the first bit of the line and alternates with each following bit.
- R7: `ttxReq` is high, one clock after the count, for every `hCount` with `WIN_START - reqAdvance <= hCount < WIN_START + W - reqAdvance` on an eligible line. W is the total window length of 1402 clocks for the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| is625Mode | input | 1 | 1 when the raster is the 625-line standard |
| ttxEnable | input | 1 | Global teletext enable |
| lineNum | input | 10 | Frame line number from the timing generator |
| hCount | input | 11 | Horizontal clock count within the line, 0 to 1727 |
| oddLineEn | input | 17 | Per-line enables for lines 6 to 22, bit 0 = line 6 |
| evenLineEn | input | 18 | Per-line enables for lines 318 to 335, bit 0 = line 318 |
| reqAdvance | input | 8 | Number of clocks by which the request leads the bit window |
| testPatEn | input | 1 | Replace input data with the alternating pattern |
| ttxDataIn | input | 1 | Serial teletext data from the source |
| ttxReq | output | 1 | Data request to the source |
| bitValid | output | 1 | Strobe on the last clock of each bit period |
| bitData | output | 1 | Bit captured with the strobe |

## Verification
The hardest condition to reach from the ports is the last, partial 37-bit group of a window, together with the ends of the request window under the largest advance. Both need a full-length eligible line whose counts are driven through to the end. The bench therefore acts as its own timing generator. It steps `hCount` through complete 1728-clock lines and places chosen line numbers at the field boundaries: 5/6, 22/23, 317/318 and 335/336. On each line it varies the advance (0, 3, 17, 255) and the test mode. A behavioural model computes the bit-end offsets from the 3/4 rule and is compared with the outputs on every clock.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

  typedef struct packed {
    logic reqWin;   // request window open for the current count
    logic bitEnd;   // current clock is the last of a bit period
    logic bitOdd;   // index of the current bit is odd
  } ttxStrobeT;

  // length in clocks of a window of nBits, where within each group the
  // positions that are a nonzero multiple of stride (0-based) are short
  function automatic int windowCycles(int nBits, int groupBits, int stride);
    int total;
    int p;
    total = 0;
    for (int i = 0; i < nBits; i++) begin
      p = i % groupBits;
      total += ((p != 0) && (p % stride == 0)) ? 3 : 4;
    end
    return total;
  endfunction

endpackage

// File: rtl/ttx_line_gate.sv
module ttx_line_gate #(
  parameter int L_W         = 10,
  parameter int ODD_FIRST   = 6,
  parameter int ODD_LINES   = 17,
  parameter int EVEN_FIRST  = 318,
  parameter int EVEN_LINES  = 18
) (
  input  logic                  is625Mode,
  input  logic                  ttxEnable,
  input  logic [L_W-1:0]        lineNum,
  input  logic [ODD_LINES-1:0]  oddLineEn,
  input  logic [EVEN_LINES-1:0] evenLineEn,
  output logic                  lineActive
);

  logic [ODD_LINES-1:0]  oddHit;
  logic [EVEN_LINES-1:0] evenHit;

  for (genvar i = 0; i < ODD_LINES; i++) begin : g_odd
    assign oddHit[i] = oddLineEn[i] && (lineNum == L_W'(ODD_FIRST + i));
  end

  for (genvar j = 0; j < EVEN_LINES; j++) begin : g_even
    assign evenHit[j] = evenLineEn[j] && (lineNum == L_W'(EVEN_FIRST + j));
  end

  assign lineActive = is625Mode && ttxEnable && ((|oddHit) || (|evenHit));

endmodule

// File: rtl/ttx_bit_ctrl.sv
module ttx_bit_ctrl
  import ttx_pkg::*;
#(
  parameter int H_W         = 11,
  parameter int ADV_W       = 8,
  parameter int WIN_START   = 264,
  parameter int NUM_BITS    = 360,
  parameter int GROUP_BITS  = 37,
  parameter int SHORT_STRIDE = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineActive,
  input  logic [H_W-1:0]   hCount,
  input  logic [ADV_W-1:0] reqAdvance,
  output ttxStrobeT        strobe
);

  localparam int WIN_LEN = windowCycles(NUM_BITS, GROUP_BITS, SHORT_STRIDE);
  localparam int POS_W   = $clog2(GROUP_BITS + 1);
  localparam int BIT_W   = $clog2(NUM_BITS + 1);
  localparam logic [H_W:0] START_X = (H_W+1)'(WIN_START);
  localparam logic [H_W:0] END_X   = (H_W+1)'(WIN_START + WIN_LEN);
  localparam logic [H_W-1:0] START_H = H_W'(WIN_START);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(GROUP_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NUM_BITS - 1);

  // short-position mask of one group, bit p set when position p (0-based) lasts 3 clocks
  function automatic logic [GROUP_BITS-1:0] shortMask();
    logic [GROUP_BITS-1:0] m;
    m = '0;
    for (int p = 1; p < GROUP_BITS; p++) begin
      if (p % SHORT_STRIDE == 0) m[p] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [GROUP_BITS-1:0] SHORT_MASK = shortMask();

  logic             running;
  logic [1:0]       phase;
  logic [POS_W-1:0] posIdx;
  logic [BIT_W-1:0] bitIdx;

  logic             startNow;
  logic             curActive;
  logic [1:0]       curPhase;
  logic [POS_W-1:0] curPos;
  logic [BIT_W-1:0] curBit;
  logic [1:0]       lastPhase;
  logic             bitEnd;
  logic [H_W:0]     hAdv;

  assign startNow  = lineActive && (hCount == START_H);
  assign curActive = lineActive && (startNow || running);
  assign curPhase  = startNow ? 2'd0 : phase;
  assign curPos    = startNow ? '0 : posIdx;
  assign curBit    = startNow ? '0 : bitIdx;
  assign lastPhase = SHORT_MASK[curPos] ? 2'd2 : 2'd3;
  assign bitEnd    = curActive && (curPhase == lastPhase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= '0;
      posIdx  <= '0;
      bitIdx  <= '0;
    end else if (!curActive) begin
      running <= 1'b0;
    end else if (bitEnd) begin
      running <= (curBit != BIT_LAST);
      phase   <= '0;
      posIdx  <= (curPos == POS_LAST) ? '0 : curPos + 1'b1;
      bitIdx  <= curBit + 1'b1;
    end else begin
      running <= 1'b1;
      phase   <= curPhase + 2'd1;
      posIdx  <= curPos;
      bitIdx  <= curBit;
    end
  end

  assign hAdv = {1'b0, hCount} + (H_W+1)'(reqAdvance);

  always_comb begin
    strobe.reqWin = lineActive && (hAdv >= START_X) && (hAdv < END_X);
    strobe.bitEnd = bitEnd;
    strobe.bitOdd = curBit[0];
  end

endmodule

// File: rtl/ttx_bit_dp.sv
module ttx_bit_dp
  import ttx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ttxStrobeT strobe,
  input  logic      testPatEn,
  input  logic      ttxDataIn,
  output logic      ttxReq,
  output logic      bitValid,
  output logic      bitData
);

  logic nextData;

  always_comb begin
    if (!strobe.bitEnd)  nextData = 1'b0;
    else if (testPatEn)  nextData = ~strobe.bitOdd;
    else                 nextData = ttxDataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ttxReq   <= 1'b0;
      bitValid <= 1'b0;
      bitData  <= 1'b0;
    end else begin
      ttxReq   <= strobe.reqWin;
      bitValid <= strobe.bitEnd;
      bitData  <= nextData;
    end
  end

endmodule

// File: rtl/ttx_pacer.sv
module ttx_pacer
  import ttx_pkg::*;
#(
  parameter int H_W          = 11,
  parameter int L_W          = 10,
  parameter int ADV_W        = 8,
  parameter int WIN_START    = 264,
  parameter int NUM_BITS     = 360,
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int ODD_FIRST    = 6,
  parameter int ODD_LINES    = 17,
  parameter int EVEN_FIRST   = 318,
  parameter int EVEN_LINES   = 18
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  is625Mode,
  input  logic                  ttxEnable,
  input  logic [L_W-1:0]        lineNum,
  input  logic [H_W-1:0]        hCount,
  input  logic [ODD_LINES-1:0]  oddLineEn,
  input  logic [EVEN_LINES-1:0] evenLineEn,
  input  logic [ADV_W-1:0]      reqAdvance,
  input  logic                  testPatEn,
  input  logic                  ttxDataIn,
  output logic                  ttxReq,
  output logic                  bitValid,
  output logic                  bitData
);

  logic      lineActive;
  ttxStrobeT strobe;

  ttx_line_gate #(
    .L_W(L_W), .ODD_FIRST(ODD_FIRST), .ODD_LINES(ODD_LINES),
    .EVEN_FIRST(EVEN_FIRST), .EVEN_LINES(EVEN_LINES)
  ) gate_i (
    .is625Mode(is625Mode), .ttxEnable(ttxEnable), .lineNum(lineNum),
    .oddLineEn(oddLineEn), .evenLineEn(evenLineEn), .lineActive(lineActive)
  );

  ttx_bit_ctrl #(
    .H_W(H_W), .ADV_W(ADV_W), .WIN_START(WIN_START), .NUM_BITS(NUM_BITS),
    .GROUP_BITS(GROUP_BITS), .SHORT_STRIDE(SHORT_STRIDE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .lineActive(lineActive), .hCount(hCount),
    .reqAdvance(reqAdvance), .strobe(strobe)
  );

  ttx_bit_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .testPatEn(testPatEn),
    .ttxDataIn(ttxDataIn), .ttxReq(ttxReq), .bitValid(bitValid), .bitData(bitData)
  );

endmodule

// File: rtl/ttx_pacer_chk.sv
module ttx_pacer_chk (
  input logic clk,
  input logic rstN,
  input logic is625Mode,
  input logic ttxEnable,
  input logic ttxReq,
  input logic bitValid,
  input logic bitData
);

  logic [2:0] sinceLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sinceLast <= 3'd7;
    else if (bitValid)     sinceLast <= 3'd1;
    else if (sinceLast != 3'd7) sinceLast <= sinceLast + 3'd1;
  end

  // R4: strobe is a single-cycle pulse
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R3: consecutive strobes are at least three clocks apart
  p_min_period_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (sinceLast >= 3'd3));

  // R5: data is zero between strobes
  p_data_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> !bitData);

  // R2: global enable low silences the next cycle
  p_global_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ttxEnable |=> (!ttxReq && !bitValid));

  // R2: non-625 mode silences the next cycle
  p_mode_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !is625Mode |=> (!ttxReq && !bitValid));

  // R1: outputs clear during reset
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r1: assert (!ttxReq && !bitValid && !bitData);
    end
  end

endmodule

bind ttx_pacer ttx_pacer_chk chk_i (
  .clk(clk), .rstN(rstN), .is625Mode(is625Mode), .ttxEnable(ttxEnable),
  .ttxReq(ttxReq), .bitValid(bitValid), .bitData(bitData)
);

// File: tb/ttx_pacer_tb_top.sv
`timescale 1ns/1ps
module ttx_pacer_tb_top;

  localparam int LINE_CLKS = 1728;
  localparam int START     = 264;
  localparam int NBITS     = 360;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        is625Mode = 1'b1;
  logic        ttxEnable = 1'b0;
  logic [9:0]  lineNum = '0;
  logic [10:0] hCount = '0;
  logic [16:0] oddLineEn = '0;
  logic [17:0] evenLineEn = '0;
  logic [7:0]  reqAdvance = '0;
  logic        testPatEn = 1'b0;
  logic        ttxDataIn = 1'b0;
  logic        ttxReq, bitValid, bitData;

  int compared = 0;
  int mismatched = 0;
  int endAt[0:2047];
  int winLen;
  int lfsr = 32'h1234_5678;

  always #10 clk = ~clk;

  ttx_pacer dut_i (
    .clk(clk), .rstN(rstN), .is625Mode(is625Mode), .ttxEnable(ttxEnable),
    .lineNum(lineNum), .hCount(hCount), .oddLineEn(oddLineEn),
    .evenLineEn(evenLineEn), .reqAdvance(reqAdvance), .testPatEn(testPatEn),
    .ttxDataIn(ttxDataIn), .ttxReq(ttxReq), .bitValid(bitValid), .bitData(bitData)
  );

  // bit-end offsets from the 3/4 rule: positions 10,19,28,37 of each 37-group are short
  task automatic buildTable();
    int off;
    int pos;
    for (int i = 0; i < 2048; i++) endAt[i] = -1;
    off = 0;
    for (int b = 0; b < NBITS; b++) begin
      pos = (b % 37) + 1;
      off += (pos == 10 || pos == 19 || pos == 28 || pos == 37) ? 3 : 4;
      endAt[off - 1] = b;
    end
    winLen = off;
  endtask

  function automatic bit lineOk(int ln);
    if (!is625Mode || !ttxEnable) return 0;
    if (ln >= 6 && ln <= 22)    return oddLineEn[ln - 6];
    if (ln >= 318 && ln <= 335) return evenLineEn[ln - 318];
    return 0;
  endfunction

  task automatic check(string tag, bit er, bit ev, bit ed);
    compared++;
    if (ttxReq !== er || bitValid !== ev || bitData !== ed) begin
      mismatched++;
      $display("FAIL [%s] line %0d h %0d: req(R7) %b exp %b, valid(R4) %b exp %b, data(R5) %b exp %b",
               tag, lineNum, hCount, ttxReq, er, bitValid, ev, bitData, ed);
    end
  endtask

  // drives one full line and compares every clock
  task automatic runLine(int ln, string tag);
    bit er, ev, ed, act;
    int off, strobes, expStrobes;
    er = 0; ev = 0; ed = 0; strobes = 0;
    lineNum = 10'(ln);
    act = lineOk(ln);
    expStrobes = act ? NBITS : 0;
    for (int h = 0; h < LINE_CLKS; h++) begin
      @(negedge clk);
      check(tag, er, ev, ed);
      if (bitValid === 1'b1) strobes++;
      hCount = 11'(h);
      lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) != 0 ? 32'h04C1_1DB7 : 0);
      ttxDataIn = lfsr[7];
      off = h - START;
      er = act && (h + int'(reqAdvance) >= START) && (h + int'(reqAdvance) < START + winLen);
      ev = act && off >= 0 && off < winLen && endAt[off] >= 0;
      ed = ev ? (testPatEn ? (endAt[off] % 2 == 0) : ttxDataIn) : 1'b0;
    end
    @(negedge clk);
    check(tag, er, ev, ed);
    if (bitValid === 1'b1) strobes++;
    compared++;
    if (strobes != expStrobes) begin
      mismatched++;
      $display("FAIL [R3] line %0d strobe count %0d exp %0d", ln, strobes, expStrobes);
    end
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    buildTable();
    repeat (3) @(negedge clk);
    compared++;
    if (ttxReq !== 1'b0 || bitValid !== 1'b0 || bitData !== 1'b0) begin
      mismatched++;
      $display("FAIL [R1] reset outputs %b%b%b exp 000", ttxReq, bitValid, bitData);
    end
    rstN = 1'b1;
    @(negedge clk);
    compared++;
    if (ttxReq !== 1'b0 || bitValid !== 1'b0 || bitData !== 1'b0) begin
      mismatched++;
      $display("FAIL [R1] post-reset outputs %b%b%b exp 000", ttxReq, bitValid, bitData);
    end

    ttxEnable = 1'b1;
    oddLineEn = 17'h1_FFFD;          // line 7 disabled
    evenLineEn = 18'h3_FFFF;
    runLine(6, "R3 basic, adv 0");
    reqAdvance = 8'd255;
    runLine(22, "R7 adv 255");
    reqAdvance = 8'd17; testPatEn = 1'b1;
    runLine(318, "R6 test pattern");
    reqAdvance = 8'd0; testPatEn = 1'b0;
    runLine(335, "R5 last even line");
    runLine(5, "R2 below odd range");
    runLine(23, "R2 above odd range");
    runLine(317, "R2 below even range");
    runLine(336, "R2 above even range");
    runLine(7, "R2 line bit clear");
    is625Mode = 1'b0;
    runLine(6, "R2 525 mode");
    is625Mode = 1'b1; ttxEnable = 1'b0;
    runLine(6, "R2 global off");
    ttxEnable = 1'b1; testPatEn = 1'b1; reqAdvance = 8'd3;
    runLine(320, "R6 adv 3");
    testPatEn = 1'b0;
    runLine(8, "R3 repeat");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule